// File: doc/BRIEF.md
# Legacy Power-Up Configuration Loader

This block configures an add-in card as it comes out of reset, on a card that can run with or without plug-and-play support. An active-low mode pin picks the path. With the pin high the card is left for the host to configure through plug-and-play. The loader then stays idle and never touches the EEPROM. With the pin low the card runs in legacy mode. The loader samples a five-bit strap field once and treats it as a record number. It fetches that record's four 16-bit words from a serial EEPROM over a three-wire chip-select / clock / data-in / data-out link. It writes the words into the resource registers: two I/O base addresses, interrupt routing and DMA routing. Finally it marks the logical device active, so no host configuration cycle is needed.

The EEPROM holds 256 words of 16 bits. The lower half is reserved for plug-and-play resource data. The upper half holds the legacy records, four words each. Strap value 0 is reserved, so values 1 to 31 give 31 usable configurations.

The controller is a state machine with these states. `ST_SAMPLE` is the reset state and captures the straps and the mode pin. `ST_PNP` is the terminal state for plug-and-play mode. `ST_UNUSED` is the terminal state for strap code 0. `ST_ISSUE` starts one EEPROM word read. `ST_WAIT` waits for that word and stores it. `ST_SETTLE` is a one-cycle gap after the last store. `ST_DONE` is the terminal loaded state.

The transitions are:
- SAMPLE→PNP when the mode pin is high.
- SAMPLE→UNUSED when the strap code is 0.
- SAMPLE→ISSUE in every other case.
- ISSUE→WAIT on the next cycle.
- WAIT→ISSUE when a word arrives and more words remain.
- WAIT→SETTLE when the fourth word arrives.
- SETTLE→DONE on the next cycle.

Top module: `legacy_cfg_loader`

## Requirements
- R1: While `legacy_n` is held high, the chip select never rises. `dev_active` and `load_done` stay 0, and all four configuration outputs stay 0.
- R2: `sw_code` and `legacy_n` are captured on the first rising clock edge after `rst_n` is released. Later changes to either pin have no effect until the next reset.
- R3: Strap code 0 starts no EEPROM access. `dev_active` and `load_done` stay 0, and the configuration outputs stay 0.
- R4: Word w (w = 0..3) of the record for code c is read from EEPROM word address 128 + 4*c + w. The words are read in increasing w order.
- R5: Each word is read in its own frame while `ee_cs` is high. The frame drives eleven bits on `ee_di`, MSB first: a start bit 1, opcode bits 1 then 0, and the eight address bits. Each of these bits is launched while `ee_sk` is low. After those eleven bits, 16 bits are sampled from `ee_do`, MSB first, at `ee_sk` rising edges. `ee_sk` is low whenever `ee_cs` is low.
- R6: The words go to the outputs in this order: word 0 to `io_base_a`, word 1 to `io_base_b`, word 2 to `irq_route`, word 3 to `dma_route`.
- R7: `load_done` and `dev_active` rise together, one clock after `dma_route` is written. Both then stay high until reset.
- R8: During reset every output is 0.
- R9: The boundary codes 1 and 31 load the records at addresses 132..135 and 252..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_n | input | 1 | Mode pin: 0 selects legacy loading, 1 selects plug-and-play |
| sw_code | input | 5 | Strap field that selects the record |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| io_base_a | output | 16 | First I/O base address (record word 0) |
| io_base_b | output | 16 | Second I/O base address (record word 1) |
| irq_route | output | 16 | Interrupt routing word (record word 2) |
| dma_route | output | 16 | DMA routing word (record word 3) |
| dev_active | output | 1 | Logical device active |
| load_done | output | 1 | Record fully loaded |

## Verification
The load path is tried with a mid-range code and with both boundary codes, 1 and 31. A wrong address calculation or a swapped word order shows up as mismatching words, because the EEPROM model returns address-dependent data that differs in every word. The mode pin high and strap code 0 are the two quiet paths, and each must leave the link untouched. A run where the straps and the mode pin change just after capture distinguishes a one-shot sample from a live input. The edge where `dma_route` changes is used to pin `load_done` to exactly one clock later.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    localparam logic [1:0] MW_OP_READ = 2'b10;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_PNP,
        ST_UNUSED,
        ST_ISSUE,
        ST_WAIT,
        ST_SETTLE,
        ST_DONE
    } ld_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SHIFT,
        RD_END
    } rd_state_t;
endpackage

// File: rtl/cfgl_mw_reader.sv
module cfgl_mw_reader
    import cfgl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int FRAME = CMD_W + WORD_W;
    localparam int CNT_W = $clog2(FRAME + 1);

    rd_state_t         rstate;
    logic [CNT_W-1:0]  cnt;
    logic [CMD_W-1:0]  cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rstate  <= RD_IDLE;
            ee_cs   <= 1'b0;
            ee_sk   <= 1'b0;
            ee_di   <= 1'b0;
            cnt     <= '0;
            cmd     <= '0;
            rd_data <= '0;
        end else begin
            unique case (rstate)
                RD_IDLE: begin
                    if (start) begin
                        rstate <= RD_SHIFT;
                        ee_cs  <= 1'b1;
                        ee_sk  <= 1'b0;
                        cnt    <= '0;
                        cmd    <= {1'b1, MW_OP_READ, addr};
                        ee_di  <= 1'b1;
                    end
                end
                RD_SHIFT: begin
                    if (!ee_sk) begin
                        ee_sk <= 1'b1;
                        if (cnt >= CNT_W'(CMD_W))
                            rd_data <= {rd_data[WORD_W-2:0], ee_do};
                    end else begin
                        ee_sk <= 1'b0;
                        if (cnt == CNT_W'(FRAME - 1)) begin
                            rstate <= RD_END;
                            ee_cs  <= 1'b0;
                            ee_di  <= 1'b0;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            cmd   <= cmd << 1;
                            ee_di <= cmd[CMD_W-2];
                        end
                    end
                end
                RD_END: rstate <= RD_IDLE;
                default: rstate <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_valid = (rstate == RD_END);
    end

    // R5: serial clock rests low whenever the part is deselected
    assert_sk_low_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);
    // R5: every frame opens with the start bit on DI
    assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> ee_di);
endmodule

// File: rtl/cfgl_regfile.sv
module cfgl_regfile #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 4,
    localparam int IDX_W  = $clog2(N_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [WORD_W-1:0]             wdata,
    output logic [N_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && idx == IDX_W'(g))
                words[g] <= wdata;
        end
    end

    // R6: slots only change on a write strobe
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words));
endmodule

// File: rtl/legacy_cfg_loader.sv
module legacy_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int SW_W   = 5,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_n,
    input  logic [SW_W-1:0]   sw_code,
    input  logic              ee_do,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic [WORD_W-1:0] io_base_a,
    output logic [WORD_W-1:0] io_base_b,
    output logic [WORD_W-1:0] irq_route,
    output logic [WORD_W-1:0] dma_route,
    output logic              dev_active,
    output logic              load_done
);
    localparam int REC_WORDS = 4;
    localparam int IDX_W     = $clog2(REC_WORDS);
    localparam int REC_BASE  = 1 << (ADDR_W - 1);

    ld_state_t          state, state_nx;
    logic [SW_W-1:0]    sw_q;
    logic               mode_pnp_q;
    logic [IDX_W-1:0]   idx;
    logic               rd_start, rd_valid, wr_en;
    logic [WORD_W-1:0]  rd_data;
    logic [ADDR_W-1:0]  rec_addr;
    logic [REC_WORDS-1:0][WORD_W-1:0] cfg_words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SAMPLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SAMPLE: begin
                if (legacy_n)            state_nx = ST_PNP;
                else if (sw_code == '0)  state_nx = ST_UNUSED;
                else                     state_nx = ST_ISSUE;
            end
            ST_ISSUE:  state_nx = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid)
                    state_nx = (idx == IDX_W'(REC_WORDS - 1)) ? ST_SETTLE : ST_ISSUE;
            end
            ST_SETTLE: state_nx = ST_DONE;
            ST_PNP, ST_UNUSED, ST_DONE: state_nx = state;
            default:   state_nx = ST_SAMPLE;
        endcase
    end

    always_comb begin
        rd_start   = (state == ST_ISSUE);
        wr_en      = (state == ST_WAIT) && rd_valid;
        load_done  = (state == ST_DONE);
        dev_active = (state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q       <= '0;
            mode_pnp_q <= 1'b0;
            idx        <= '0;
        end else begin
            if (state == ST_SAMPLE) begin
                sw_q       <= sw_code;
                mode_pnp_q <= legacy_n;
            end
            if (wr_en && idx != IDX_W'(REC_WORDS - 1))
                idx <= idx + 1'b1;
        end
    end

    assign rec_addr = ADDR_W'(REC_BASE) + ADDR_W'({sw_q, idx});

    cfgl_mw_reader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_start),
        .addr     (rec_addr),
        .ee_do    (ee_do),
        .ee_cs    (ee_cs),
        .ee_sk    (ee_sk),
        .ee_di    (ee_di),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    cfgl_regfile #(.WORD_W(WORD_W), .N_WORDS(REC_WORDS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .idx   (idx),
        .wdata (rd_data),
        .words (cfg_words)
    );

    assign io_base_a = cfg_words[0];
    assign io_base_b = cfg_words[1];
    assign irq_route = cfg_words[2];
    assign dma_route = cfg_words[3];

    // R2: straps are frozen after the capture cycle
    assert_sw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SAMPLE) |=> $stable(sw_q) && $stable(mode_pnp_q));
    // R1: plug-and-play mode never selects the EEPROM
    assert_pnp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pnp_q |-> !ee_cs && !dev_active);
    // R3: reserved code leaves the device inactive and the link idle
    assert_reserved_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNUSED) |-> !ee_cs && !dev_active && !load_done);
    // R7: done is sticky and follows the settle cycle
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done && dev_active);
    assert_done_after_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> $past(state) == ST_SETTLE);
endmodule

// File: tb/legacy_cfg_loader_test.sv
module legacy_cfg_loader_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_n = 1'b0;
    logic [4:0]  sw_code = '0;
    logic        ee_do = 1'b0;
    logic        ee_cs, ee_sk, ee_di;
    logic [15:0] io_base_a, io_base_b, irq_route, dma_route;
    logic        dev_active, load_done;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    legacy_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .legacy_n(legacy_n), .sw_code(sw_code), .ee_do(ee_do),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .io_base_a(io_base_a), .io_base_b(io_base_b), .irq_route(irq_route),
        .dma_route(dma_route), .dev_active(dev_active), .load_done(load_done)
    );

    function automatic logic [15:0] word_of(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    // serial EEPROM model
    int         rise_cnt = 0;
    int         frames = 0;
    int         frame_err = 0;
    logic [2:0] hdr = '0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] addr_log [4];

    always @(posedge ee_cs) begin
        rise_cnt = 0;
        hdr = '0;
        frames++;
    end

    always @(posedge ee_sk) begin
        if (!ee_cs) frame_err++;
        else begin
            if (rise_cnt < 3) hdr = {hdr[1:0], ee_di};
            else if (rise_cnt < 11) cmd_addr = {cmd_addr[6:0], ee_di};
            rise_cnt++;
            if (rise_cnt == 11) begin
                if (hdr != 3'b110) frame_err++;
                if (frames >= 1 && frames <= 4) addr_log[frames-1] = cmd_addr;
            end
        end
    end

    always @(negedge ee_sk) begin
        logic [15:0] w;
        if (ee_cs && rise_cnt >= 11 && rise_cnt < 27) begin
            w = word_of(cmd_addr);
            ee_do = w[26 - rise_cnt];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode, input logic [4:0] code);
        rst_n = 1'b0;
        legacy_n = mode;
        sw_code = code;
        frames = 0;
        frame_err = 0;
        for (int i = 0; i < 4; i++) addr_log[i] = 'x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 5'd7);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di, "R8", "link idle in reset", {ee_cs, ee_sk, ee_di}, 0);
        check(io_base_a == 0 && io_base_b == 0, "R8", "io bases zero", {io_base_a, io_base_b}, 0);
        check(irq_route == 0 && dma_route == 0, "R8", "routing zero", {irq_route, dma_route}, 0);
        check(!dev_active && !load_done, "R8", "inactive", {dev_active, load_done}, 0);
    endtask

    task automatic t_quiet(input logic mode, input logic [4:0] code, input string req);
        do_reset(mode, code);
        repeat (300) @(negedge clk);
        check(frames == 0, req, "no chip select", frames, 0);
        check(!dev_active && !load_done, req, "stays inactive", {dev_active, load_done}, 0);
        check({io_base_a, io_base_b, irq_route, dma_route} == '0, req, "config zero",
              io_base_a | io_base_b | irq_route | dma_route, 0);
    endtask

    task automatic t_load(input logic [4:0] code, input bit wiggle, input string req);
        int  cyc;
        logic [7:0] base;
        do_reset(1'b0, code);
        if (wiggle) begin
            @(negedge clk);
            sw_code = code ^ 5'h1F;
            legacy_n = 1'b1;
        end
        cyc = 0;
        while (dma_route == 0 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 2000, "R7", "dma_route written", cyc, 0);
        check(!load_done && !dev_active, "R7", "done low at dma write", {load_done, dev_active}, 0);
        @(negedge clk);
        check(load_done && dev_active, "R7", "done one clock later", {load_done, dev_active}, 2'b11);
        base = 8'd128 + {code, 2'b00};
        check(io_base_a == word_of(base), req, "R6 word0 io_base_a", io_base_a, word_of(base));
        check(io_base_b == word_of(base + 8'd1), req, "R6 word1 io_base_b", io_base_b, word_of(base + 8'd1));
        check(irq_route == word_of(base + 8'd2), req, "R6 word2 irq_route", irq_route, word_of(base + 8'd2));
        check(dma_route == word_of(base + 8'd3), req, "R6 word3 dma_route", dma_route, word_of(base + 8'd3));
        check(frames == 4, "R5", "four frames", frames, 4);
        check(frame_err == 0, "R5", "frame format", frame_err, 0);
        for (int w = 0; w < 4; w++)
            check(addr_log[w] == base + 8'(w), "R4", "address order", addr_log[w], base + 8'(w));
        repeat (20) @(negedge clk);
        check(load_done && dev_active && frames == 4, "R7", "done sticky", {load_done, dev_active}, 2'b11);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();                 // R8
        t_quiet(1'b1, 5'd12, "R1");      // plug-and-play mode
        t_quiet(1'b0, 5'd0, "R3");       // reserved code
        t_load(5'd13, 1'b0, "R4");       // mid-range code
        t_load(5'd1, 1'b0, "R9");        // lowest code
        t_load(5'd31, 1'b0, "R9");       // highest code
        t_load(5'd9, 1'b1, "R2");        // straps change after capture
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule